// File: doc/BRIEF.md
# Link Receiver Control Register Block

This block is the register file that configures and monitors one display-link receiver port. Software reaches it over a simple synchronous bus with a word address, write data, a write strobe and read data. It holds five words: a control word, a lane-power word, a transfer-unit-size word, an interrupt mask word and a sticky status word. The control and lane-power fields are decoded into plain outputs that drive the receiver: enable, PLL enable, clock source, auto-train, framing mode, error-correction enables, training pattern, lane count, colour depth and per-lane power codes.

Three hardware event inputs report link progress: bit lock, symbol lock and inter-lane alignment. Each event sets a sticky status bit, which software clears by writing a one to it. Any status bit whose mask bit is zero raises the interrupt output. Several fields are stored in compact encodings: the lane count and the transfer-unit size are kept minus one, and the colour depth uses a non-monotonic two-bit code. The block presents each field decoded to its natural value.

Word map: address 0 control, 1 lane power, 2 transfer-unit size, 3 interrupt mask, 4 status. Other addresses read zero and ignore writes.

Top module: `lrx_reg_top`

## Requirements
- R1: Reset (active-low `rstN`, asynchronous) clears the control, lane-power, transfer-unit-size and status words and the read data to zero, and sets the mask word to all ones, so `irqOut` is 0.
- R2: A write with `busWe` high stores `busWdata` into the word at `busAddr` (0 control, 1 lane power, 2 transfer-unit size, 3 mask). `busRdata` is registered: it shows the word at the address presented on the previous clock edge. Address 4 reads status bits 10:8 with all other bits zero. Addresses 5 to 7 read zero, and writes to them change nothing.
- R3: Control bit 31 drives `rxEnable`, bit 13 `pllEnable`, bit 10 `autoTrain`, bit 6 `enhFraming`, bit 27 `errCorrEn[1]`, bit 26 `errCorrEn[0]`. Bit 4 drives `clkSelPixel` (0 raw clock, 1 pixel-derived clock).
- R4: `trainPattern` is the two-bit control field at bits TP_POS+1:TP_POS (default 8, alternative 28): 0 pattern one, 1 pattern two, 2 idle, 3 none.
- R5: `laneCount` equals control bits 21:19 plus one (range 1 to 8).
- R6: `bitsPerColour` decodes control bits 17:16: 0 gives 8, 1 gives 10, 2 gives 6, 3 gives 12.
- R7: `lane1Pwr` is lane-power bits 27:26 and `lane0Pwr` is bits 25:24 (code 2 powered down, code 0 active).
- R8: `tuSize` equals transfer-unit-size bits 30:25 plus one (range 1 to 64).
- R9: On the clock edge where `evtAlign`, `evtSymLock` or `evtBitLock` is high, status bit 10, 9 or 8 respectively becomes 1. It stays 1 until it is cleared.
- R10: Writing address 4 clears each status bit at 10:8 whose write-data bit is 1. A 0 in the write data leaves that status bit unchanged.
- R11: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R12: `irqOut` is high exactly when some status bit at 10:8 is 1 and mask bit at the same position is 0. A mask bit of 1 blocks its status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 3 | Word address |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe |
| busRdata | output | 32 | Registered read data |
| evtBitLock | input | 1 | Bit-lock event |
| evtSymLock | input | 1 | Symbol-lock event |
| evtAlign | input | 1 | Inter-lane alignment event |
| irqOut | output | 1 | Interrupt request |
| rxEnable | output | 1 | Receiver enable |
| pllEnable | output | 1 | Receiver PLL enable |
| clkSelPixel | output | 1 | Clock source select, 1 = pixel-derived |
| autoTrain | output | 1 | Automatic training enable |
| enhFraming | output | 1 | Enhanced framing enable |
| errCorrEn | output | 2 | Error-correction enables |
| trainPattern | output | 2 | Training pattern code |
| laneCount | output | 4 | Lane count, 1 to 8 |
| bitsPerColour | output | 5 | Colour depth in bits |
| lane0Pwr | output | 2 | Lane 0 power-down code |
| lane1Pwr | output | 2 | Lane 1 power-down code |
| tuSize | output | 7 | Transfer-unit size, 1 to 64 |

## Verification
The two functions that can meet in one cycle are a hardware lock event and a software write-one-to-clear aimed at the same status bit. The bench drives an event pulse on the same clock edge as a status write that carries a one in that bit. It then reads the status word back and expects the bit to be set. The reference model carries the same rule, so the interrupt output on the following cycles is judged against it as well.

// File: rtl/lrx_pkg.sv
package lrx_pkg;

  typedef struct packed {
    logic wrCtl;
    logic wrMisc;
    logic wrTu;
    logic wrMask;
    logic clrStat;
  } lrxStrobes_t;

  typedef enum logic [2:0] {
    SEL_CTL  = 3'd0,
    SEL_MISC = 3'd1,
    SEL_TU   = 3'd2,
    SEL_MASK = 3'd3,
    SEL_STAT = 3'd4,
    SEL_NONE = 3'd7
  } lrxRdSel_t;

  localparam int unsigned ADDR_CTL  = 0;
  localparam int unsigned ADDR_MISC = 1;
  localparam int unsigned ADDR_TU   = 2;
  localparam int unsigned ADDR_MASK = 3;
  localparam int unsigned ADDR_STAT = 4;

  function automatic logic [4:0] decodeDepth(input logic [1:0] code);
    case (code)
      2'd1:    decodeDepth = 5'd10;
      2'd2:    decodeDepth = 5'd6;
      2'd3:    decodeDepth = 5'd12;
      default: decodeDepth = 5'd8;
    endcase
  endfunction

endpackage

// File: rtl/lrx_ctrl.sv
module lrx_ctrl
  import lrx_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output lrxStrobes_t       strobes,
  output lrxRdSel_t         rdSel
);

  always_comb begin
    strobes = '0;
    rdSel   = SEL_NONE;
    case (int'(busAddr))
      ADDR_CTL: begin
        strobes.wrCtl = busWe;
        rdSel         = SEL_CTL;
      end
      ADDR_MISC: begin
        strobes.wrMisc = busWe;
        rdSel          = SEL_MISC;
      end
      ADDR_TU: begin
        strobes.wrTu = busWe;
        rdSel        = SEL_TU;
      end
      ADDR_MASK: begin
        strobes.wrMask = busWe;
        rdSel          = SEL_MASK;
      end
      ADDR_STAT: begin
        strobes.clrStat = busWe;
        rdSel           = SEL_STAT;
      end
      default: ;
    endcase
  end

  // R2: at most one register is targeted by a bus access
  always_comb begin
    if (!$isunknown(strobes)) begin
      p_onehot_strobes_r2: assert ($onehot0(strobes))
        else $error("write strobes not one-hot");
    end
  end

endmodule

// File: rtl/lrx_datapath.sv
module lrx_datapath
  import lrx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TP_POS   = 8,
  parameter int LANE_POS = 19,
  parameter int LANE_W   = 3,
  parameter int BPC_POS  = 16,
  parameter int TU_POS   = 25,
  parameter int TU_W     = 6,
  parameter int STAT_LSB = 8,
  parameter int NUM_EVT  = 3,
  parameter int PWR_POS  = 24,
  parameter int NUM_PWR  = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  lrxStrobes_t             strobes,
  input  lrxRdSel_t               rdSel,
  input  logic [DATA_W-1:0]       busWdata,
  input  logic [NUM_EVT-1:0]      evtIn,
  output logic [DATA_W-1:0]       busRdata,
  output logic                    irqOut,
  output logic [DATA_W-1:0]       ctlWord,
  output logic [LANE_W:0]         laneCount,
  output logic [4:0]              bitsPerColour,
  output logic [1:0]              trainPattern,
  output logic [NUM_PWR-1:0][1:0] lanePwr,
  output logic [TU_W:0]           tuSize
);

  localparam int STAT_MSB = STAT_LSB + NUM_EVT - 1;

  logic [DATA_W-1:0]  miscReg;
  logic [DATA_W-1:0]  tuReg;
  logic [DATA_W-1:0]  maskReg;
  logic [NUM_EVT-1:0] statReg;
  logic [NUM_EVT-1:0] maskBits;
  logic [DATA_W-1:0]  statWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlWord <= '0;
      miscReg <= '0;
      tuReg   <= '0;
      maskReg <= '1;
    end else begin
      if (strobes.wrCtl)  ctlWord <= busWdata;
      if (strobes.wrMisc) miscReg <= busWdata;
      if (strobes.wrTu)   tuReg   <= busWdata;
      if (strobes.wrMask) maskReg <= busWdata;
    end
  end

  // sticky status bits: event set beats write-one-to-clear
  for (genvar i = 0; i < NUM_EVT; i++) begin : g_stat
    logic clrHit;
    assign clrHit = strobes.clrStat && busWdata[STAT_LSB+i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          statReg[i] <= 1'b0;
      else if (evtIn[i])  statReg[i] <= 1'b1;
      else if (clrHit)    statReg[i] <= 1'b0;
    end

    p_evt_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
      evtIn[i] |=> statReg[i]);
    p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
      (clrHit && !evtIn[i]) |=> !statReg[i]);
    p_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
      (!clrHit && !evtIn[i]) |=> $stable(statReg[i]));
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
      (clrHit && evtIn[i]) |=> statReg[i]);
    p_irq_raise_r12: assert property (@(posedge clk) disable iff (!rstN)
      (evtIn[i] && !maskBits[i] && !strobes.wrMask) |=> irqOut);
  end

  assign maskBits = maskReg[STAT_MSB:STAT_LSB];
  assign irqOut   = |(statReg & ~maskBits);

  always_comb begin
    statWord                    = '0;
    statWord[STAT_MSB:STAT_LSB] = statReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else begin
      case (rdSel)
        SEL_CTL:  busRdata <= ctlWord;
        SEL_MISC: busRdata <= miscReg;
        SEL_TU:   busRdata <= tuReg;
        SEL_MASK: busRdata <= maskReg;
        SEL_STAT: busRdata <= statWord;
        default:  busRdata <= '0;
      endcase
    end
  end

  // field decoding
  assign laneCount     = {1'b0, ctlWord[LANE_POS +: LANE_W]} + 1'b1;
  assign bitsPerColour = decodeDepth(ctlWord[BPC_POS +: 2]);
  assign trainPattern  = ctlWord[TP_POS +: 2];
  assign tuSize        = {1'b0, tuReg[TU_POS +: TU_W]} + 1'b1;

  for (genvar l = 0; l < NUM_PWR; l++) begin : g_pwr
    assign lanePwr[l] = miscReg[PWR_POS + 2*l +: 2];
  end

  p_mask_reset_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (&maskReg && statReg == '0));
  p_full_mask_r12: assert property (@(posedge clk) disable iff (!rstN)
    (&maskBits) |-> !irqOut);

endmodule

// File: rtl/lrx_reg_top.sv
module lrx_reg_top
  import lrx_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int TP_POS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  output logic [31:0]       busRdata,
  input  logic              evtBitLock,
  input  logic              evtSymLock,
  input  logic              evtAlign,
  output logic              irqOut,
  output logic              rxEnable,
  output logic              pllEnable,
  output logic              clkSelPixel,
  output logic              autoTrain,
  output logic              enhFraming,
  output logic [1:0]        errCorrEn,
  output logic [1:0]        trainPattern,
  output logic [3:0]        laneCount,
  output logic [4:0]        bitsPerColour,
  output logic [1:0]        lane0Pwr,
  output logic [1:0]        lane1Pwr,
  output logic [6:0]        tuSize
);

  lrxStrobes_t     strobes;
  lrxRdSel_t       rdSel;
  logic [31:0]     ctlWord;
  logic [1:0][1:0] lanePwr;

  lrx_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  lrx_datapath #(
    .DATA_W (32),
    .TP_POS (TP_POS)
  ) dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .rdSel         (rdSel),
    .busWdata      (busWdata),
    .evtIn         ({evtAlign, evtSymLock, evtBitLock}),
    .busRdata      (busRdata),
    .irqOut        (irqOut),
    .ctlWord       (ctlWord),
    .laneCount     (laneCount),
    .bitsPerColour (bitsPerColour),
    .trainPattern  (trainPattern),
    .lanePwr       (lanePwr),
    .tuSize        (tuSize)
  );

  assign rxEnable    = ctlWord[31];
  assign pllEnable   = ctlWord[13];
  assign autoTrain   = ctlWord[10];
  assign enhFraming  = ctlWord[6];
  assign clkSelPixel = ctlWord[4];
  assign errCorrEn   = {ctlWord[27], ctlWord[26]};
  assign lane0Pwr    = lanePwr[0];
  assign lane1Pwr    = lanePwr[1];

endmodule

// File: tb/lrx_reg_top_tb.sv
module lrx_reg_top_tb_top;

  localparam int TPP = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        evtBitLock = 1'b0, evtSymLock = 1'b0, evtAlign = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut, rxEnable, pllEnable, clkSelPixel, autoTrain, enhFraming;
  logic [1:0]  errCorrEn, trainPattern, lane0Pwr, lane1Pwr;
  logic [3:0]  laneCount;
  logic [4:0]  bitsPerColour;
  logic [6:0]  tuSize;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lrx_reg_top #(.ADDR_W(3), .TP_POS(TPP)) dut_i (.*);

  // behavioural reference model
  logic [31:0] mCtl, mMisc, mTu, mMask, mRd;
  logic [2:0]  mStat;

  function automatic int depthOf(input int code);
    case (code)
      0: return 8;
      1: return 10;
      2: return 6;
      default: return 12;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCtl <= 0; mMisc <= 0; mTu <= 0; mMask <= 32'hFFFF_FFFF; mStat <= 0; mRd <= 0;
    end else begin
      case (busAddr)
        3'd0: mRd <= mCtl;
        3'd1: mRd <= mMisc;
        3'd2: mRd <= mTu;
        3'd3: mRd <= mMask;
        3'd4: mRd <= {21'd0, mStat, 8'd0};
        default: mRd <= 0;
      endcase
      if (busWe && busAddr == 3'd0) mCtl  <= busWdata;
      if (busWe && busAddr == 3'd1) mMisc <= busWdata;
      if (busWe && busAddr == 3'd2) mTu   <= busWdata;
      if (busWe && busAddr == 3'd3) mMask <= busWdata;
      begin
        logic [2:0] ev;
        logic [2:0] nx;
        ev = {evtAlign, evtSymLock, evtBitLock};
        nx = mStat;
        if (busWe && busAddr == 3'd4) nx = nx & ~busWdata[10:8];
        mStat <= nx | ev;
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R2", "busRdata", busRdata, mRd);
      chk("R12", "irqOut", irqOut, |(mStat & ~mMask[10:8]));
      chk("R3", "rxEnable", rxEnable, mCtl[31]);
      chk("R3", "pllEnable", pllEnable, mCtl[13]);
      chk("R3", "autoTrain", autoTrain, mCtl[10]);
      chk("R3", "enhFraming", enhFraming, mCtl[6]);
      chk("R3", "clkSelPixel", clkSelPixel, mCtl[4]);
      chk("R3", "errCorrEn", errCorrEn, {mCtl[27], mCtl[26]});
      chk("R4", "trainPattern", trainPattern, (mCtl >> TPP) & 3);
      chk("R5", "laneCount", laneCount, ((mCtl >> 19) & 7) + 1);
      chk("R6", "bitsPerColour", bitsPerColour, depthOf((mCtl >> 16) & 3));
      chk("R7", "lane1Pwr", lane1Pwr, (mMisc >> 26) & 3);
      chk("R7", "lane0Pwr", lane0Pwr, (mMisc >> 24) & 3);
      chk("R8", "tuSize", tuSize, ((mTu >> 25) & 63) + 1);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    busAddr = 3'(a); busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdChk(input int a, input logic [31:0] exp, input string req);
    @(negedge clk);
    busAddr = 3'(a); busWe = 1'b0;
    @(negedge clk);
    chk(req, "read", busRdata, exp);
  endtask

  task automatic pulse(input logic [2:0] ev);
    @(negedge clk);
    {evtAlign, evtSymLock, evtBitLock} = ev;
    @(negedge clk);
    {evtAlign, evtSymLock, evtBitLock} = 3'b000;
  endtask

  task automatic summary;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset values
    chk("R1", "irqOut after reset", irqOut, 0);
    chk("R1", "laneCount after reset", laneCount, 1);
    rdChk(3, 32'hFFFF_FFFF, "R1");
    rdChk(0, 32'h0, "R1");
    rdChk(4, 32'h0, "R1");

    // R3..R6: sweep control fields
    for (int k = 0; k < 32; k++) begin
      logic [31:0] v;
      v = {k[0], 3'd0, k[1], k[2], 4'd0, 3'(k), 2'(k >> 3), 2'd0, k[3], 2'd0, k[4],
           2'(k >> 1), 1'b0, k[2], 1'b0, k[0], 4'd0};
      wr(0, v);
      rdChk(0, v, "R2");
    end
    wr(0, 32'hFFFF_FFFF);
    wr(0, 32'h0000_0010);
    chk("R3", "clkSelPixel pixel", clkSelPixel, 1);

    // R7: lane power codes
    wr(1, 32'h0A00_0000);
    chk("R7", "lanes powered down", {lane1Pwr, lane0Pwr}, 4'b1010);
    wr(1, 32'h0800_0000);
    chk("R7", "lane0 active", {lane1Pwr, lane0Pwr}, 4'b1000);

    // R8: transfer-unit size extremes
    wr(2, 32'd63 << 25);
    chk("R8", "tuSize 64", tuSize, 64);
    wr(2, 32'd0);
    chk("R8", "tuSize 1", tuSize, 1);
    wr(2, 32'd47 << 25);
    rdChk(2, 32'd47 << 25, "R2");

    // R2: unmapped addresses
    wr(5, 32'hDEAD_BEEF);
    wr(7, 32'h1234_5678);
    rdChk(5, 0, "R2");
    rdChk(7, 0, "R2");
    rdChk(3, 32'hFFFF_FFFF, "R2");

    // R9 / R12: events with mask fully set, then unmasked
    pulse(3'b001);
    rdChk(4, 32'h0000_0100, "R9");
    chk("R12", "masked irq", irqOut, 0);
    wr(3, 32'hFFFF_FEFF);
    chk("R12", "unmasked bit lock irq", irqOut, 1);
    pulse(3'b110);
    rdChk(4, 32'h0000_0700, "R9");

    // R10: writing zeros leaves status, ones clear
    wr(4, 32'h0);
    rdChk(4, 32'h0000_0700, "R10");
    wr(4, 32'h0000_0100);
    rdChk(4, 32'h0000_0600, "R10");
    chk("R12", "irq after bit lock cleared", irqOut, 0);

    // R11: set and clear in the same cycle
    @(negedge clk);
    busAddr = 3'd4; busWdata = 32'h0000_0700; busWe = 1'b1; evtBitLock = 1'b1;
    @(negedge clk);
    busWe = 1'b0; evtBitLock = 1'b0;
    rdChk(4, 32'h0000_0100, "R11");
    chk("R11", "irq after set wins", irqOut, 1);

    // R12: open all mask bits
    wr(3, 32'h0);
    pulse(3'b100);
    chk("R12", "irq align unmasked", irqOut, 1);
    wr(4, 32'h0000_0700);
    chk("R12", "irq cleared", irqOut, 0);

    repeat (4) @(negedge clk);
    summary();
  end

endmodule